// File: doc/BRIEF.md
# Double-Buffered Character Row Buffer

This block sits in the refresh path of a text-mode display and holds the character codes of one displayed row. It has two shift registers, each one character row long. The refresh register sends its codes to the character generator, one code per character clock. On every ordinary scan line its output is fed back to its input, so the same row is redrawn on each scan line of the row. The prefetch register is filled from refresh memory with the codes of the row that comes next. The block therefore reads memory once per character row, not once per scan line.

The timing generator holds the end-of-row input high for the last scan line of each row. During that line the refresh register still presents the old row. At the same time the refresh register takes its input from the prefetch register, so after one full line of character clocks it holds the new row in order. When end-of-row falls, the fill controller captures the row start address and issues one memory read per character position at consecutive addresses. The fill has the remaining scan lines of the row to complete. If end-of-row rises again while a fill is still running, the fill is abandoned and a sticky underrun flag is set.

Top module: `crt_rowbuf`

## Requirements
- R1: After a synchronous active-low reset, `char_code` is the blank code 0x20 and `rd_req`, `fill_done` and `underrun` are 0. Both registers hold 0x20 in every position.
- R2: While `eor_scan` is low, each `char_tick` advances `char_code` by one position. After NCHARS ticks the output repeats the same NCHARS codes in the same order.
- R3: During a scan line with `eor_scan` high, `char_code` presents the old row's codes in order over NCHARS ticks. After that line it presents the prefetched codes in the order they were read from memory.
- R4: On the clock edge after `eor_scan` falls, `rd_req` rises, `rd_addr` equals `row_addr`, and `fill_done` is 0. Each accepted `rd_ack` advances `rd_addr` by one, wrapping modulo 2^ADDR_W. Without an ack, `rd_req` and `rd_addr` hold.
- R5: After the NCHARS-th accepted ack, `rd_req` falls and `fill_done` rises on the same edge. They stay that way until the next fill starts.
- R6: If `eor_scan` rises while a fill is still requesting, `underrun` becomes 1 and `rd_req` falls on that edge. `underrun` stays 1 until reset, even across later fills that complete normally.
- R7: `eor_scan` rising with no fill in progress leaves `underrun` at 0. The first end-of-row line after reset transfers blank codes.
- R8: While `char_tick` is low, `char_code` does not change, including while a fill is writing the prefetch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Synchronous reset, active low |
| char_tick | input | 1 | Character clock enable, one shift per pulse |
| eor_scan | input | 1 | High for the whole end-of-row scan line |
| row_addr | input | ADDR_W | Memory address of the first code of the next row |
| rd_req | output | 1 | Memory read request, held until acknowledged |
| rd_addr | output | ADDR_W | Address of the pending read |
| rd_ack | input | 1 | Read accepted; `rd_data` is valid in this cycle |
| rd_data | input | CODE_W | Character code returned by memory |
| char_code | output | CODE_W | Code at the current character position |
| fill_done | output | 1 | Prefetch register holds a complete row |
| underrun | output | 1 | Sticky: a fill was cut off by end-of-row |

## Verification
A wrong state in the prefetch register cannot be seen until the next end-of-row line has finished. After that line, every position of the following scan line shows it at `char_code`, so the bench compares whole lines position by position after each transfer. A miscounting fill controller shows on `rd_addr` within one acknowledge, and on the timing of `fill_done` at the last read. A refresh register that fails to recirculate corrupts the second scan line of a row, which is checked separately from the first.

// File: rtl/crt_rowbuf_pkg.sv
// Package: shared constants and types for the character row buffer.
// Assumes character codes are eight bits wide, with 0x20 as the blank.
package crt_rowbuf_pkg;
    localparam int unsigned CODE_W_DEF = 8;
    localparam logic [7:0]  BLANK_CODE = 8'h20;

    typedef enum logic {
        FILL_IDLE = 1'b0,
        FILL_RUN  = 1'b1
    } fill_state_t;
endpackage

// File: rtl/crt_rowbuf_shreg.sv
// Module: a DEPTH-stage shift register of W-bit words with an enable.
// A word enters at stage 0 and leaves at stage DEPTH-1 after DEPTH shifts.
// Assumes din is valid in every cycle where shift_en is high.
module crt_rowbuf_shreg #(
    parameter int unsigned DEPTH = 80,
    parameter int unsigned W     = 8,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int unsigned TOTAL_W = DEPTH * W;

    logic [TOTAL_W-1:0] chain;

    // Reset every stage to INIT; otherwise shift one word per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {DEPTH{INIT}};
        end else if (shift_en) begin
            chain <= {chain[TOTAL_W-W-1:0], din};
        end
    end

    assign dout = chain[TOTAL_W-1 -: W];
endmodule

// File: rtl/crt_rowbuf_fill.sv
// Module: fill controller for the prefetch register.
// Starts a fill of NCHARS reads at row_addr when eor_scan falls. It hands
// each acknowledged code to the prefetch register through wr_en. If
// eor_scan rises before the fill completes, the fill is abandoned and a
// sticky underrun flag is set.
// Assumes memory answers each read with rd_ack in some later cycle.
module crt_rowbuf_fill
    import crt_rowbuf_pkg::*;
#(
    parameter int unsigned NCHARS = 80,
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eor_scan,
    input  logic [ADDR_W-1:0] row_addr,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic              fill_done,
    output logic              underrun
);
    localparam int unsigned CNT_W = (NCHARS > 1) ? $clog2(NCHARS) : 1;
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(NCHARS - 1);

    fill_state_t       state;
    logic              eor_q;
    logic [CNT_W-1:0]  pos;
    logic              eor_rise;
    logic              eor_fall;

    assign eor_rise = eor_scan & ~eor_q;
    assign eor_fall = ~eor_scan & eor_q;
    assign wr_en    = (state == FILL_RUN) & rd_ack & ~eor_scan;
    assign rd_req   = (state == FILL_RUN);

    // Keep the previous level of eor_scan for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) eor_q <= 1'b0;
        else        eor_q <= eor_scan;
    end

    // Sequence the reads: start on fall, count acks, abort on rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= FILL_IDLE;
            pos       <= '0;
            rd_addr   <= '0;
            fill_done <= 1'b0;
        end else if (eor_fall) begin
            state     <= FILL_RUN;
            pos       <= '0;
            rd_addr   <= row_addr;
            fill_done <= 1'b0;
        end else if (state == FILL_RUN) begin
            if (eor_rise) begin
                state <= FILL_IDLE;
            end else if (wr_en) begin
                rd_addr <= rd_addr + 1'b1;
                if (pos == LAST_POS) begin
                    state     <= FILL_IDLE;
                    fill_done <= 1'b1;
                end else begin
                    pos <= pos + 1'b1;
                end
            end
        end
    end

    // Latch an underrun until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              underrun <= 1'b0;
        else if (eor_rise && state == FILL_RUN) underrun <= 1'b1;
    end
endmodule

// File: rtl/crt_rowbuf.sv
// Module: double-buffered character row buffer (top).
// The refresh register recirculates on each char_tick. While eor_scan is
// high it loads from the prefetch register instead. The prefetch register
// is written by the fill controller, and on end-of-row ticks it shifts in
// step with the refresh register.
// Assumes eor_scan is held for a full line of NCHARS character ticks.
module crt_rowbuf
    import crt_rowbuf_pkg::*;
#(
    parameter int unsigned NCHARS = 80,
    parameter int unsigned CODE_W = CODE_W_DEF,
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_tick,
    input  logic              eor_scan,
    input  logic [ADDR_W-1:0] row_addr,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [CODE_W-1:0] rd_data,
    output logic [CODE_W-1:0] char_code,
    output logic              fill_done,
    output logic              underrun
);
    localparam logic [CODE_W-1:0] BLANK = CODE_W'(BLANK_CODE);

    logic              fill_wr;
    logic              nxt_shift;
    logic [CODE_W-1:0] nxt_din;
    logic [CODE_W-1:0] nxt_out;
    logic [CODE_W-1:0] ref_din;
    logic [CODE_W-1:0] ref_out;

    // Select prefetch input: memory data on fill writes, else recirculate.
    always_comb begin
        nxt_shift = fill_wr | (eor_scan & char_tick);
        nxt_din   = fill_wr ? rd_data : nxt_out;
    end

    // Select refresh input: prefetch output on end-of-row, else feedback.
    always_comb begin
        ref_din = eor_scan ? nxt_out : ref_out;
    end

    crt_rowbuf_fill #(
        .NCHARS (NCHARS),
        .ADDR_W (ADDR_W)
    ) fill_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eor_scan  (eor_scan),
        .row_addr  (row_addr),
        .rd_ack    (rd_ack),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr),
        .wr_en     (fill_wr),
        .fill_done (fill_done),
        .underrun  (underrun)
    );

    crt_rowbuf_shreg #(
        .DEPTH (NCHARS),
        .W     (CODE_W),
        .INIT  (BLANK)
    ) nxt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (nxt_shift),
        .din      (nxt_din),
        .dout     (nxt_out)
    );

    crt_rowbuf_shreg #(
        .DEPTH (NCHARS),
        .W     (CODE_W),
        .INIT  (BLANK)
    ) ref_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (char_tick),
        .din      (ref_din),
        .dout     (ref_out)
    );

    assign char_code = ref_out;
endmodule

// File: rtl/crt_rowbuf_chk.sv
// Module: assertion checker for crt_rowbuf, attached with bind.
// Observes the top-level ports only.
module crt_rowbuf_chk #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              char_tick,
    input logic              eor_scan,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [CODE_W-1:0] char_code,
    input logic              fill_done,
    input logic              underrun
);
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !char_tick |=> $stable(char_code)); // R8

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !eor_scan) |=> (rd_req && $stable(rd_addr))); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack && !eor_scan) |=> (!rd_req || rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R4

    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> !rd_req); // R5

    AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun); // R6

    AST_UNDERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> $past(rd_req && eor_scan)); // R6
endmodule

bind crt_rowbuf crt_rowbuf_chk #(
    .CODE_W (CODE_W),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .char_tick (char_tick),
    .eor_scan  (eor_scan),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_ack    (rd_ack),
    .char_code (char_code),
    .fill_done (fill_done),
    .underrun  (underrun)
);

// File: tb/crt_rowbuf_tb_top.sv
// Bench: walks a table of row base addresses through fill/transfer/scan,
// then runs directed tests for underrun, tick hold and reset.
module crt_rowbuf_tb_top;
    localparam int unsigned NCHARS = 80;
    localparam int unsigned CODE_W = 8;
    localparam int unsigned ADDR_W = 14;
    localparam int unsigned NROWS  = 4;
    localparam logic [ADDR_W-1:0] BASES [NROWS] =
        '{14'h0000, 14'h0050, 14'h1FB0, 14'h3FD0};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              char_tick = 1'b0;
    logic              eor_scan = 1'b0;
    logic [ADDR_W-1:0] row_addr = '0;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [CODE_W-1:0] rd_data = '0;
    logic [CODE_W-1:0] char_code;
    logic              fill_done;
    logic              underrun;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    crt_rowbuf #(.NCHARS(NCHARS), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .char_tick(char_tick), .eor_scan(eor_scan),
        .row_addr(row_addr), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .char_code(char_code),
        .fill_done(fill_done), .underrun(underrun)
    );

    function automatic logic [CODE_W-1:0] pat(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    function automatic logic [CODE_W-1:0] exp_code(input logic [ADDR_W-1:0] base,
                                                   input logic blank, input int p);
        logic [ADDR_W-1:0] a;
        a = base + ADDR_W'(p);
        return blank ? 8'h20 : pat(a);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One scan line: compare each position, then tick. Starts at negedge.
    task automatic scan_line(input string req, input logic [ADDR_W-1:0] base,
                             input logic blank, input logic do_check);
        int bad = 0;
        logic [CODE_W-1:0] first_act = '0;
        logic [CODE_W-1:0] first_exp = '0;
        for (int p = 0; p < NCHARS; p++) begin
            if (char_code !== exp_code(base, blank, p) && bad == 0) begin
                first_act = char_code;
                first_exp = exp_code(base, blank, p);
            end
            if (char_code !== exp_code(base, blank, p)) bad++;
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
        if (do_check) check(req, 32'(first_act), 32'(first_exp));
    endtask

    // Answer up to n reads, checking addresses; returns address mismatches.
    task automatic do_fill(input logic [ADDR_W-1:0] base, input int n, output int bad);
        int cnt = 0;
        bad = 0;
        while (rd_req && cnt < n) begin
            if (rd_addr !== ADDR_W'(base + ADDR_W'(cnt))) bad++;
            rd_ack  = 1'b1;
            rd_data = pat(rd_addr);
            @(negedge clk);
            cnt++;
        end
        rd_ack = 1'b0;
    endtask

    initial begin
        int bad;
        logic [ADDR_W-1:0] prev_base;
        logic prev_blank;
        logic [CODE_W-1:0] held;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 char_code", 32'(char_code), 32'h20);
        check("R1 rd_req/fill_done/underrun", {29'b0, rd_req, fill_done, underrun}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        scan_line("R1 blank line after reset", '0, 1'b1, 1'b1);

        // R7: first end-of-row transfers blanks, no underrun
        row_addr = BASES[0];
        eor_scan = 1'b1;
        scan_line("R7 first transfer blank", '0, 1'b1, 1'b1);
        check("R7 no underrun idle", 32'(underrun), 32'h0);
        eor_scan = 1'b0;
        @(negedge clk);
        // R4: fill start
        check("R4 rd_req after fall", 32'(rd_req), 32'h1);
        check("R4 rd_addr start", 32'(rd_addr), 32'(BASES[0]));
        check("R4 fill_done cleared", 32'(fill_done), 32'h0);
        do_fill(BASES[0], NCHARS, bad);
        check("R4 address sequence", 32'(bad), 32'h0);
        check("R5 done after last ack", {30'b0, fill_done, rd_req}, 32'h2);
        // R2: refresh unaffected by fill until transfer
        scan_line("R2 still blank before transfer", '0, 1'b1, 1'b1);

        prev_base  = BASES[0];
        prev_blank = 1'b1;
        // Walk the table: the loaded row becomes visible one transfer later.
        for (int i = 0; i < NROWS; i++) begin
            row_addr = BASES[(i + 1) % NROWS];
            eor_scan = 1'b1;
            scan_line("R3 old row during transfer", prev_base, prev_blank, 1'b1);
            check("R7 no underrun on complete fill", 32'(underrun), 32'h0);
            eor_scan = 1'b0;
            @(negedge clk);
            check("R4 rd_addr at fill start", 32'(rd_addr), 32'(BASES[(i + 1) % NROWS]));
            held = char_code;
            do_fill(BASES[(i + 1) % NROWS], NCHARS, bad);
            check("R4 address sequence (wrap)", 32'(bad), 32'h0);
            check("R8 code held during fill", 32'(char_code), 32'(held));
            check("R5 fill_done", 32'(fill_done), 32'h1);
            scan_line("R3 new row after transfer", BASES[i], 1'b0, 1'b1);
            scan_line("R2 recirculated row", BASES[i], 1'b0, 1'b1);
            prev_base  = BASES[i];
            prev_blank = 1'b0;
        end

        // R8: no tick for several cycles
        held = char_code;
        repeat (5) @(negedge clk);
        check("R8 hold without tick", 32'(char_code), 32'(held));

        // R6: underrun on partial fill
        eor_scan = 1'b1;
        scan_line("R6 transfer", '0, 1'b0, 1'b0);
        row_addr = 14'h0123;
        eor_scan = 1'b0;
        @(negedge clk);
        do_fill(14'h0123, 10, bad);
        check("R6 partial fill addresses", 32'(bad), 32'h0);
        eor_scan = 1'b1;
        @(negedge clk);
        check("R6 underrun set", 32'(underrun), 32'h1);
        check("R6 rd_req dropped", 32'(rd_req), 32'h0);
        scan_line("R6 transfer after underrun", '0, 1'b0, 1'b0);
        row_addr = 14'h0200;
        eor_scan = 1'b0;
        @(negedge clk);
        do_fill(14'h0200, NCHARS, bad);
        check("R6 sticky after good fill", 32'(underrun), 32'h1);
        eor_scan = 1'b1;
        scan_line("R6 transfer", '0, 1'b0, 1'b0);
        eor_scan = 1'b0;
        @(negedge clk);
        scan_line("R3 row after recovery", 14'h0200, 1'b0, 1'b1);

        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears underrun", {29'b0, rd_req, fill_done, underrun}, 32'h0);
        check("R1 reset blank code", 32'(char_code), 32'h20);
        rst_n = 1'b1;
        @(negedge clk);
        scan_line("R1 blank after mid reset", '0, 1'b1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule